// File: doc/BRIEF.md
# Audio Sample Error Concealment Unit

This unit sits after the second-stage error correction of a digital audio playback path. It takes one channel of 16-bit two's-complement samples. Each sample comes with a flag that says whether the correction stage could not repair it. Good samples pass through untouched. A bad sample that stands alone between good ones is replaced by the midpoint of its neighbours. Once bad samples come two or more in a row, the unit repeats the last value it sent. A host-controlled mute input forces silence at once.

The input is a stream of valid beats, each carrying a flag and a data word. The output is a stream of valid beats carrying data. The unit looks one sample ahead so that it knows the neighbour that follows the sample being decided. Each sample therefore comes out with a fixed delay of two input beats, on the clock after the beat that lets it be decided. Cycles without an input beat do nothing at all.

Top module: `audio_conceal`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0 and the remembered last output is 0. A flagged first sample therefore conceals against a history of zero.
- R2: The first two input beats after reset produce no output. From then on, each input beat (in_valid=1) produces exactly one out_valid pulse, on the next clock. That pulse carries the decision for the sample that arrived two beats earlier.
- R3: A sample with in_flag=0 (flag 1 means bad) comes out unchanged, unless mute is active.
- R4: A flagged sample whose preceding sample was unflagged (or which is the first sample after reset) and whose following sample is unflagged comes out as floor((last_output + following) / 2). The sum is formed in 17-bit two's complement and rounded toward negative infinity.
- R5: A flagged sample whose following sample is also flagged, or whose preceding sample was flagged, repeats the previous output value.
- R6: If mute is 1 on the beat that decides a sample, that sample comes out as 0, and 0 becomes the remembered last output.
- R7: After mute returns to 0, flagged samples keep coming out as 0 until the first unflagged sample. That sample passes through and ends the silence.
- R8: On cycles with in_valid=0 the output does not pulse and no state changes. The value of mute on those cycles has no effect.
- R9: A run of flagged samples of any length, including runs longer than three, keeps repeating the value held before the run. The first unflagged sample after the run passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat strobe |
| in_flag | input | 1 | 1 = sample left uncorrected |
| in_data | input | 16 | Two's-complement sample |
| mute | input | 1 | Host mute request, sampled on input beats |
| out_valid | output | 1 | Output beat strobe |
| out_data | output | 16 | Concealed sample |

## Verification
The bench sweeps every 8-sample flag pattern, starting each from reset. It uses data that includes full-scale positive and negative values and odd sums. This catches a midpoint that truncates toward zero or overflows. It also catches a design that interpolates inside runs or looks at the wrong neighbour. Idle cycles with mute toggled are placed between beats, so a design that advances or samples mute without a beat is caught. Mute windows followed by flagged samples, and forced runs longer than three, expose a mute that releases too early and a run counter that wraps instead of saturating.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    SEL_PASS   = 2'd0,
    SEL_MID    = 2'd1,
    SEL_REPEAT = 2'd2,
    SEL_SILENT = 2'd3
  } sel_e;
endpackage

// File: rtl/cc_lookahead.sv
module cc_lookahead #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_flag,
  input  logic [DATA_W-1:0] in_data,
  output logic              c_flag,
  output logic [DATA_W-1:0] c_data,
  output logic              f_flag,
  output logic [DATA_W-1:0] f_data,
  output logic              primed
);
  localparam int FW = $clog2(DEPTH + 1);

  logic [FW-1:0]     fill_q, fill_d;
  logic              near_flag_q, far_flag_q;
  logic [DATA_W-1:0] near_data_q, far_data_q;

  always_comb begin
    fill_d = fill_q;
    if (adv && (fill_q != FW'(DEPTH))) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q      <= '0;
      near_flag_q <= 1'b0;
      near_data_q <= '0;
      far_flag_q  <= 1'b0;
      far_data_q  <= '0;
    end else if (adv) begin
      fill_q      <= fill_d;
      near_flag_q <= in_flag;
      near_data_q <= in_data;
      far_flag_q  <= near_flag_q;
      far_data_q  <= near_data_q;
    end
  end

  assign c_flag = far_flag_q;
  assign c_data = far_data_q;
  assign f_flag = near_flag_q;
  assign f_data = near_data_q;
  assign primed = (fill_q == FW'(DEPTH));
endmodule

// File: rtl/cc_run_count.sv
module cc_run_count #(
  parameter int RUN_MAX = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic                         bad,
  output logic [$clog2(RUN_MAX+1)-1:0] run
);
  localparam int CW = $clog2(RUN_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!bad)                        cnt_d = '0;
    else if (cnt_q == CW'(RUN_MAX))  cnt_d = cnt_q;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end

  assign run = cnt_q;
endmodule

// File: rtl/cc_select.sv
module cc_select
  import cc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CW     = 2
) (
  input  logic              mute,
  input  logic              silent_q,
  input  logic              c_flag,
  input  logic [DATA_W-1:0] c_data,
  input  logic              f_flag,
  input  logic [DATA_W-1:0] f_data,
  input  logic [DATA_W-1:0] last_out,
  input  logic [CW-1:0]     run_prev,
  output logic [DATA_W-1:0] y,
  output logic              silent_d,
  output sel_e              sel
);
  logic signed [DATA_W:0] sum;
  logic signed [DATA_W:0] half;

  always_comb begin
    sum  = $signed({last_out[DATA_W-1], last_out}) + $signed({f_data[DATA_W-1], f_data});
    half = sum >>> 1;
  end

  always_comb begin
    silent_d = silent_q;
    if (mute) begin
      sel      = SEL_SILENT;
      silent_d = 1'b1;
    end else if (silent_q && c_flag) begin
      sel = SEL_SILENT;
    end else if (!c_flag) begin
      sel      = SEL_PASS;
      silent_d = 1'b0;
    end else if ((run_prev == '0) && !f_flag) begin
      sel = SEL_MID;
    end else begin
      sel = SEL_REPEAT;
    end
  end

  always_comb begin
    case (sel)
      SEL_PASS:   y = c_data;
      SEL_MID:    y = half[DATA_W-1:0];
      SEL_REPEAT: y = last_out;
      default:    y = '0;
    endcase
  end
endmodule

// File: rtl/audio_conceal.sv
module audio_conceal
  import cc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RUN_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_flag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              mute,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int CW = $clog2(RUN_MAX + 1);

  logic              rst_meta_q, rst_core_n;
  logic              c_flag, f_flag, primed, decide;
  logic [DATA_W-1:0] c_data, f_data;
  logic [CW-1:0]     run_prev;
  logic              silent_q, silent_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              ov_q;
  sel_e              sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  assign decide = in_valid && primed;

  cc_lookahead #(.DATA_W(DATA_W), .DEPTH(2)) i_look (
    .clk(clk), .rst_n(rst_core_n), .adv(in_valid),
    .in_flag(in_flag), .in_data(in_data),
    .c_flag(c_flag), .c_data(c_data),
    .f_flag(f_flag), .f_data(f_data), .primed(primed)
  );

  cc_run_count #(.RUN_MAX(RUN_MAX)) i_run (
    .clk(clk), .rst_n(rst_core_n), .adv(decide), .bad(c_flag), .run(run_prev)
  );

  cc_select #(.DATA_W(DATA_W), .CW(CW)) i_sel (
    .mute(mute), .silent_q(silent_q),
    .c_flag(c_flag), .c_data(c_data), .f_flag(f_flag), .f_data(f_data),
    .last_out(out_q), .run_prev(run_prev),
    .y(out_d), .silent_d(silent_d), .sel(sel)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_q    <= '0;
      silent_q <= 1'b0;
    end else if (decide) begin
      out_q    <= out_d;
      silent_q <= silent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ov_q <= 1'b0;
    else             ov_q <= decide;
  end

  assign out_valid = ov_q;
  assign out_data  = out_q;
endmodule

// File: rtl/audio_conceal_chk.sv
module audio_conceal_chk #(
  parameter int DATA_W = 16,
  parameter int CW     = 2
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              in_valid,
  input logic              mute,
  input logic              primed,
  input logic              c_flag,
  input logic [DATA_W-1:0] c_data,
  input logic              silent_q,
  input logic [CW-1:0]     run_prev,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  // R8: no output pulse and no output change without an input beat
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R2: beats that fill the lookahead produce no output
  assert_fill_silent_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && !primed) |=> !out_valid);

  // R3: unflagged sample passes unchanged
  assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && primed && !mute && !c_flag) |=> (out_valid && out_data == $past(c_data)));

  // R6: mute forces zero
  assert_mute_zero_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && primed && mute) |=> (out_valid && out_data == '0));

  // R5: flagged sample inside a run repeats the previous output
  assert_repeat_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && primed && !mute && !silent_q && c_flag && run_prev != '0)
      |=> (out_valid && $stable(out_data)));
endmodule

bind audio_conceal audio_conceal_chk #(.DATA_W(DATA_W), .CW(CW)) i_chk (
  .clk(clk), .rst_core_n(rst_core_n), .in_valid(in_valid), .mute(mute),
  .primed(primed), .c_flag(c_flag), .c_data(c_data), .silent_q(silent_q),
  .run_prev(run_prev), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_audio_conceal.sv
module test_audio_conceal;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_flag = 1'b0;
  logic [15:0] in_data = '0;
  logic        mute = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  audio_conceal i_audio_conceal (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flag(in_flag),
    .in_data(in_data), .mute(mute), .out_valid(out_valid), .out_data(out_data)
  );

  // reference model state
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        want_ov = 1'b0;
  bit          mon_on = 1'b0;
  int          nbeats;
  logic        s_flag[2];
  logic [15:0] s_data[2];
  logic [15:0] m_hist;
  int          m_run;
  bit          m_silent;
  int unsigned lcg = 32'h1234_5678;

  function automatic logic [15:0] floor_mid(logic [15:0] a, logic [15:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    if (s < 0 && (s % 2 != 0)) return 16'((s - 1) / 2);
    return 16'(s / 2);
  endfunction

  task automatic model_reset();
    m_hist = '0; m_run = 0; m_silent = 0; nbeats = 0;
    exp_q.delete(); tag_q.delete();
  endtask

  // decide centre s[0] with following s[1]
  task automatic model_step(logic mt);
    logic [15:0] e;
    string t;
    if (mt) begin
      e = '0; t = "R6"; m_silent = 1;
    end else if (m_silent && s_flag[0]) begin
      e = '0; t = "R7";
    end else if (!s_flag[0]) begin
      e = s_data[0]; t = m_silent ? "R7" : (m_run > 3 ? "R9" : "R3"); m_silent = 0;
    end else if (m_run == 0 && !s_flag[1]) begin
      e = floor_mid(m_hist, s_data[1]); t = "R4";
    end else begin
      e = m_hist; t = (m_run >= 3) ? "R9" : "R5";
    end
    m_run  = s_flag[0] ? m_run + 1 : 0;
    m_hist = e;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic beat(logic fl, logic [15:0] d, logic mt);
    @(negedge clk); #1;
    in_valid = 1'b1; in_flag = fl; in_data = d; mute = mt;
    if (nbeats >= 2) begin
      model_step(mt);
      want_ov = 1'b1;
    end else begin
      want_ov = 1'b0;
    end
    s_flag[0] = s_flag[1]; s_data[0] = s_data[1];
    s_flag[1] = fl;        s_data[1] = d;
    nbeats++;
  endtask

  task automatic idle(logic mt);
    @(negedge clk); #1;
    in_valid = 1'b0; in_flag = ~in_flag; in_data = ~in_data; mute = mt;
    want_ov = 1'b0;
  endtask

  task automatic do_reset();
    mon_on = 0;
    @(negedge clk); #1;
    rst_n = 0; in_valid = 0; mute = 0; want_ov = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 16'h0) begin
      failures++;
      $display("FAIL R1 reset state: valid=%0b data=%h expected valid=0 data=0000", out_valid, out_data);
    end
    model_reset();
    mon_on = 1;
  endtask

  function automatic logic [15:0] pick(int k);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    case ((lcg >> 16) % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'(lcg >> 8) ^ 16'(k);
    endcase
  endfunction

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (out_valid !== want_ov) begin
        failures++;
        $display("FAIL %s out_valid=%0b expected %0b", want_ov ? "R2" : "R8", out_valid, want_ov);
      end
      if (out_valid === 1'b1 && exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (out_data !== e) begin
          failures++;
          $display("FAIL %s out_data=%h expected %h", t, out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // exhaustive 8-sample flag sweep, R1..R5, R8, each from reset
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int k = 0; k < 10; k++) begin
        beat((k < 8) ? p[k] : 1'b0, pick(k), 1'b0);
        if (((p + k) % 3) == 0) idle(1'b1);   // R8: mute in idle ignored
      end
      idle(1'b0);
      idle(1'b0);
    end
    // mute windows (R6, R7) and long runs (R9)
    do_reset();
    for (int k = 0; k < 600; k++) begin
      logic fl, mt;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      fl = ((lcg >> 20) % 3) == 0;
      if (k >= 200 && k < 212) fl = 1'b1;
      if (k >= 400 && k < 405) fl = 1'b1;
      mt = ((k % 37) < 4);
      if ((k % 37) >= 4 && (k % 37) < 7) fl = 1'b1;
      beat(fl, pick(k), mt);
      if ((k % 5) == 0) idle(~mt);
    end
    idle(1'b0);
    idle(1'b0);
    mon_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule